// File: doc/BRIEF.md
# Sinc3 Decimating Filter with Block Averaging and Chopping

This block turns the one-bit output of a sigma-delta modulator into signed 16-bit conversion results. A third-order sinc stage reduces the sample rate first. A block-averaging stage can then reduce it further. An optional chopping mode pairs results taken with opposite input polarity, so that a fixed offset cancels. The block runs on the modulator clock and takes one modulator bit per cycle. A bit of 1 counts as +1 and a bit of 0 counts as -1.

A 16-bit control word sets the behaviour:

| Bits | Field | Meaning |
|------|-------|---------|
| [6:0] | SF | Decimation field |
| [7] | modify | Shortens one filter stage, which adds a second notch at about 4/3 of the first |
| [13:8] | AF | Averaging field |
| [15] | chop | Enables chopping |

Writing the control word, or pulsing the restart input, empties the pipeline. The filter then discards its first results while it settles.

A state machine in the averaging unit sequences the results. It has three states:

- `ST_SETTLE` drops sinc results. On the third dropped result it moves to `ST_ACCUM`.
- `ST_ACCUM` adds sinc results into a block sum. On the (AF+1)-th result it moves to `ST_RESOLVE`.
- `ST_RESOLVE` lasts one cycle. It divides the sum and emits the result, then returns to `ST_ACCUM`. In chop mode it instead toggles the phase, restarts the sinc stage and returns to `ST_SETTLE`.
- An external flush forces `ST_SETTLE` from any state.

Top module: `sdf_decimator`

## Requirements
- R1: After reset, `result` is 0, `result_valid` is 0 and `chop_phase` is 0. The control word holds 0x0007, so a constant all-ones input gives 32767.
- R2: The sinc decimation ratio is R = 8·(SF+1). With AF = 0 and chop off, consecutive results are exactly R cycles apart.
- R3: The first stage sums the last L input values, with L = R when modify is clear. For a window sum B, the result is floor(B·R²·2^15 / 2^(3·c)), where c is the smallest integer with 2^c ≥ R. For example, at SF = 2 all ones gives 13824, the repeating pattern 1,1,1,0 gives 6912, and alternating bits give 0.
- R4: Results saturate to the range -32768 to 32767 and never wrap. At SF = 7, all ones gives 32767 and all zeros gives -32768.
- R5: With modify set (control bit 7), L = 3R/4 and the scaling is unchanged. All ones gives 10368 at SF = 2 and 24576 at SF = 7.
- R6: With AF > 0, each result is the mean of AF+1 consecutive sinc results, truncated toward zero. Results are then spaced R·(AF+1) cycles apart.
- R7: After a flush, the first three sinc results are dropped. With chop off, the first result appears (AF+4)·R + 3 cycles after the cycle in which the flush is applied, within a tolerance of 3 cycles.
- R8: A pulse on `restart`, or a write on `ctrl_wr`, empties the pipeline and restarts the settling of R7. No result is emitted in the cycle that follows the flush.
- R9: With chop set (control bit 15), `chop_phase` toggles after every averaged result, and each toggle restarts the sinc settling. From the second averaged result on, the output is (phase-0 result − phase-1 result) shifted right by one, as an arithmetic shift. With chop clear, `chop_phase` never toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator bit: 1 counts as +1, 0 counts as -1 |
| ctrl_in | input | 16 | New control word |
| ctrl_wr | input | 1 | Loads `ctrl_in` and flushes the pipeline |
| restart | input | 1 | Flushes the pipeline without changing the control word |
| result | output | 16 | Signed conversion result |
| result_valid | output | 1 | One-cycle strobe that marks a new `result` |
| chop_phase | output | 1 | Input polarity for an external swap: 1 means swapped |

## Verification
The assertions assume that `ctrl_wr` and `restart` are single-cycle pulses, and that the control word changes only through a write. They also assume that every result interval is at least eight cycles long, so that no sinc strobe arrives while a block is being resolved. The stimulus meets these assumptions: it drives each write or restart for exactly one cycle, and it uses only the SF values the rules allow. The stimulus also inverts the modulator bit whenever `chop_phase` is high, which models the external input swap. With this, chopped results match the phase-0 and phase-1 values that the bench predicts from the same bit patterns.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int CTRL_W = 16;
    localparam int RES_W  = 16;
    localparam int SF_W   = 7;
    localparam int AF_W   = 6;

    typedef struct packed {
        logic            chop;
        logic            spare;
        logic [AF_W-1:0] af;
        logic            modify;
        logic [SF_W-1:0] sf;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_RESOLVE = 2'd2
    } fsm_state_t;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0007;
endpackage

// File: rtl/sdf_sinc3.sv
module sdf_sinc3 #(
    parameter int SF_W  = 7,
    parameter int RES_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bit_in,
    input  logic [SF_W-1:0]   sf,
    input  logic              modify,
    output logic              s3_valid,
    output logic [RES_W-1:0]  s3_data
);
    localparam int LOG_RMAX = SF_W + 3;
    localparam int R_MAX    = 1 << LOG_RMAX;
    localparam int ACC_W    = 2 + 3 * LOG_RMAX;
    localparam int BOX_W    = LOG_RMAX + 2;
    localparam int LEN_W    = LOG_RMAX + 1;
    localparam int SCL_W    = ACC_W + RES_W - 1;

    function automatic int ceil_log2(input logic [SF_W:0] v);
        int c;
        c = 0;
        for (int i = 0; i <= SF_W + 1; i++) begin
            if ((longint'(1) << i) < longint'(v)) c = i + 1;
        end
        return c;
    endfunction

    logic [LEN_W-1:0]        r_len, box_len;
    logic [LOG_RMAX-1:0]     tap_idx;
    logic [R_MAX-1:0]        hist;
    logic [LEN_W-1:0]        fill;
    logic [LEN_W-1:0]        dec_cnt;
    logic signed [BOX_W-1:0] box_sum, box_nxt, in_term, old_term;
    logic signed [ACC_W-1:0] int1, int2, dly1, dly2, comb_q, c1, c2;
    logic                    strobe_q;
    logic [5:0]              shift_amt;
    logic signed [SCL_W-1:0] wide, shifted;

    assign r_len   = ({{(LEN_W-SF_W){1'b0}}, sf} + LEN_W'(1)) << 3;
    assign box_len = modify ? (r_len - (r_len >> 2)) : r_len;
    assign tap_idx = LOG_RMAX'(box_len - LEN_W'(1));

    always_comb begin
        in_term  = bit_in ? BOX_W'(1) : -BOX_W'(1);
        old_term = '0;
        if (fill >= box_len) old_term = hist[tap_idx] ? BOX_W'(1) : -BOX_W'(1);
        box_nxt  = box_sum + in_term - old_term;
        c1       = int2 - dly1;
        c2       = c1 - dly2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist     <= '0;
            fill     <= '0;
            box_sum  <= '0;
            int1     <= '0;
            int2     <= '0;
            dec_cnt  <= '0;
            dly1     <= '0;
            dly2     <= '0;
            comb_q   <= '0;
            strobe_q <= 1'b0;
        end else if (flush) begin
            fill     <= '0;
            box_sum  <= '0;
            int1     <= '0;
            int2     <= '0;
            dec_cnt  <= '0;
            dly1     <= '0;
            dly2     <= '0;
            strobe_q <= 1'b0;
        end else begin
            hist     <= {hist[R_MAX-2:0], bit_in};
            if (fill != LEN_W'(R_MAX)) fill <= fill + LEN_W'(1);
            box_sum  <= box_nxt;
            int1     <= int1 + ACC_W'(box_sum);
            int2     <= int2 + int1;
            strobe_q <= 1'b0;
            if (dec_cnt == r_len - LEN_W'(1)) begin
                dec_cnt  <= '0;
                dly1     <= int2;
                dly2     <= c1;
                comb_q   <= c2;
                strobe_q <= 1'b1;
            end else begin
                dec_cnt <= dec_cnt + LEN_W'(1);
            end
        end
    end

    // Scale by 2^15 / 2^(3*ceil(log2 R)) and saturate to the output width
    always_comb begin
        shift_amt = 6'(3 * (3 + ceil_log2({1'b0, sf} + (SF_W+1)'(1))));
        wide      = {comb_q, {(RES_W-1){1'b0}}};
        shifted   = wide >>> shift_amt;
        if (shifted[SCL_W-1:RES_W-1] == {(SCL_W-RES_W+1){1'b0}} ||
            shifted[SCL_W-1:RES_W-1] == {(SCL_W-RES_W+1){1'b1}})
            s3_data = shifted[RES_W-1:0];
        else if (shifted[SCL_W-1])
            s3_data = {1'b1, {(RES_W-1){1'b0}}};
        else
            s3_data = {1'b0, {(RES_W-1){1'b1}}};
    end

    assign s3_valid = strobe_q;

    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !strobe_q);
endmodule

// File: rtl/sdf_avg_chop.sv
module sdf_avg_chop
    import sdf_pkg::*;
#(
    parameter int AF_W    = 6,
    parameter int OUT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_ext,
    input  logic              s3_valid,
    input  logic [OUT_W-1:0]  s3_data,
    input  logic [AF_W-1:0]   af,
    input  logic              chop_en,
    output logic              flush_int,
    output logic [OUT_W-1:0]  result,
    output logic              result_valid,
    output logic              chop_phase
);
    localparam int SUM_W = OUT_W + AF_W;

    fsm_state_t              state, state_nxt;
    logic [1:0]              settle_cnt;
    logic [AF_W-1:0]         blk_cnt;
    logic signed [SUM_W-1:0] blk_sum, divisor, quo;
    logic signed [OUT_W-1:0] prev_val, avg;
    logic signed [OUT_W:0]   diff_v, half_v;
    logic                    have_prev;

    assign divisor   = $signed({{(SUM_W-AF_W){1'b0}}, af} + SUM_W'(1));
    assign quo       = blk_sum / divisor;
    assign avg       = quo[OUT_W-1:0];
    assign flush_int = (state == ST_RESOLVE) && chop_en;

    always_comb begin
        if (chop_phase)
            diff_v = {prev_val[OUT_W-1], prev_val} - {avg[OUT_W-1], avg};
        else
            diff_v = {avg[OUT_W-1], avg} - {prev_val[OUT_W-1], prev_val};
        half_v = diff_v >>> 1;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SETTLE:  if (s3_valid && settle_cnt == 2'd2) state_nxt = ST_ACCUM;
            ST_ACCUM:   if (s3_valid && blk_cnt == af)      state_nxt = ST_RESOLVE;
            ST_RESOLVE: state_nxt = chop_en ? ST_SETTLE : ST_ACCUM;
            default:    state_nxt = ST_SETTLE;
        endcase
        if (flush_ext) state_nxt = ST_SETTLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt   <= '0;
            blk_cnt      <= '0;
            blk_sum      <= '0;
            prev_val     <= '0;
            have_prev    <= 1'b0;
            chop_phase   <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
        end else if (flush_ext) begin
            settle_cnt   <= '0;
            blk_cnt      <= '0;
            blk_sum      <= '0;
            have_prev    <= 1'b0;
            chop_phase   <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            unique case (state)
                ST_SETTLE: begin
                    if (s3_valid)
                        settle_cnt <= (settle_cnt == 2'd2) ? 2'd0 : settle_cnt + 2'd1;
                end
                ST_ACCUM: begin
                    if (s3_valid) begin
                        blk_sum <= blk_sum + SUM_W'($signed(s3_data));
                        blk_cnt <= blk_cnt + AF_W'(1);
                    end
                end
                ST_RESOLVE: begin
                    blk_sum <= '0;
                    blk_cnt <= '0;
                    if (!chop_en) begin
                        result       <= avg;
                        result_valid <= 1'b1;
                    end else begin
                        if (have_prev) result <= half_v[OUT_W-1:0];
                        result_valid <= have_prev;
                        prev_val     <= avg;
                        have_prev    <= 1'b1;
                        chop_phase   <= ~chop_phase;
                        settle_cnt   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_emit_from_resolve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(state == ST_RESOLVE));
    assert_phase_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chop_phase) |-> ($past(state == ST_RESOLVE) || $past(flush_ext)));
    assert_settle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> !result_valid);
    assert_flush_to_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ext |=> (state == ST_SETTLE));
endmodule

// File: rtl/sdf_decimator.sv
module sdf_decimator
    import sdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mod_bit,
    input  logic [15:0] ctrl_in,
    input  logic        ctrl_wr,
    input  logic        restart,
    output logic [15:0] result,
    output logic        result_valid,
    output logic        chop_phase
);
    ctrl_t            ctrl_q;
    logic             flush_ext, flush_int;
    logic             s3_valid;
    logic [RES_W-1:0] s3_data;

    assign flush_ext = ctrl_wr | restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_in);
    end

    sdf_sinc3 #(.SF_W(SF_W), .RES_W(RES_W)) u_sinc3 (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_ext | flush_int),
        .bit_in   (mod_bit),
        .sf       (ctrl_q.sf),
        .modify   (ctrl_q.modify),
        .s3_valid (s3_valid),
        .s3_data  (s3_data)
    );

    sdf_avg_chop #(.AF_W(AF_W), .OUT_W(RES_W)) u_avg (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_ext    (flush_ext),
        .s3_valid     (s3_valid),
        .s3_data      (s3_data),
        .af           (ctrl_q.af),
        .chop_en      (ctrl_q.chop),
        .flush_int    (flush_int),
        .result       (result),
        .result_valid (result_valid),
        .chop_phase   (chop_phase)
    );

    assert_no_emit_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ext |=> !result_valid);
endmodule

// File: tb/sdf_decimator_bench.sv
module sdf_decimator_bench;
    logic        clk = 1'b0, rst_n = 1'b0, mod_bit = 1'b1;
    logic        ctrl_wr = 1'b0, restart = 1'b0;
    logic [15:0] ctrl_in = '0;
    logic [15:0] result;
    logic        result_valid, chop_phase;

    sdf_decimator u_sdf_decimator (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .ctrl_in(ctrl_in),
        .ctrl_wr(ctrl_wr), .restart(restart), .result(result),
        .result_valid(result_valid), .chop_phase(chop_phase)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int pat = 0, pidx = 0;
    int n_cmp = 0, n_bad = 0;
    int exp_q[$];
    string tag_q[$];
    int last_valid_cyc = -1, last_gap = 0, first_cyc = -1, toggles = 0, c0 = 0;
    bit armed = 0, last_cp = 0, done = 0;

    function automatic bit gen_bit(int p, int i);
        case (p)
            0: return 1'b1;
            1: return 1'b0;
            2: return i[0];
            default: return (i % 4) != 3;
        endcase
    endfunction

    function automatic int model(int sf, bit mdf, int p, bit inv);
        longint r, l, b, v;
        int c;
        r = 8 * (sf + 1);
        l = mdf ? (3 * r) / 4 : r;
        c = 0;
        while ((longint'(1) << c) < r) c++;
        case (p)
            0: b = l;
            1: b = -l;
            2: b = 0;
            default: b = l / 2;
        endcase
        if (inv) b = -b;
        v = (b * r * r * 32768) >>> (3 * c);
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    function automatic int chop_model(int sf, bit mdf, int p);
        return (model(sf, mdf, p, 1'b0) - model(sf, mdf, p, 1'b1)) >>> 1;
    endfunction

    task automatic check(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Stimulus: modulator bit, inverted while the chop phase is swapped
    always @(negedge clk) begin
        pidx++;
        mod_bit = gen_bit(pat, pidx) ^ chop_phase;
    end

    // Monitor: pops the scoreboard on each result strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (chop_phase != last_cp) toggles++;
            last_cp = chop_phase;
            if (result_valid) begin
                if (last_valid_cyc >= 0) last_gap = cyc - last_valid_cyc;
                last_valid_cyc = cyc;
                if (armed) begin
                    first_cyc = cyc;
                    armed = 0;
                end
                if (exp_q.size() > 0) begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, int'($signed(result)), e);
                end
            end
        end
    end

    task automatic push(int n, int v, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_empty(int limit, string tag);
        int k;
        k = 0;
        while (exp_q.size() > 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        if (exp_q.size() > 0) begin
            n_bad++;
            $display("FAIL %s: actual %0d results missing expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic write_ctrl(logic [15:0] w);
        @(negedge clk);
        ctrl_in = w;
        ctrl_wr = 1'b1;
        c0 = cyc;
        @(negedge clk);
        ctrl_wr = 1'b0;
        last_valid_cyc = -1;
        toggles = 0;
        first_cyc = -1;
        armed = 1;
    endtask

    task automatic run_case(logic [15:0] w, int p, int n, int expv, string tag, int gap);
        pat = p;
        write_ctrl(w);
        push(n, expv, tag);
        wait_empty(60000, tag);
        if (gap > 0) check({tag, " gap"}, last_gap, gap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset result", int'(result), 0);
        check("R1 reset valid", int'(result_valid), 0);
        check("R1 reset chop_phase", int'(chop_phase), 0);
        push(3, 32767, "R1 default 0x0007");
        rst_n = 1'b1;
        wait_empty(2000, "R1 default");
        check("R2 default gap", last_gap, 64);
        check("R9 no toggle when chop off", toggles, 0);

        run_case(16'h0002, 0, 3, model(2, 0, 0, 0), "R3 SF2 ones", 24);
        run_case(16'h0002, 3, 3, model(2, 0, 3, 0), "R3 SF2 1110", 0);
        run_case(16'h0005, 2, 3, model(5, 0, 2, 0), "R3 SF5 alternating", 48);
        run_case(16'h0007, 1, 3, model(7, 0, 1, 0), "R4 SF7 zeros", 0);
        run_case(16'h001F, 0, 2, model(31, 0, 0, 0), "R4 SF31 ones", 256);
        run_case(16'h0082, 0, 3, model(2, 1, 0, 0), "R5 modify SF2", 0);
        run_case(16'h0087, 0, 3, model(7, 1, 0, 0), "R5 modify SF7", 0);

        run_case(16'h0302, 0, 3, model(2, 0, 0, 0), "R6 AF3 SF2", 96);
        check("R7 first result latency", first_cyc - c0, 171);

        // R8: restart mid-stream, then watch the re-settling delay
        repeat (150) @(negedge clk);
        restart = 1'b1;
        c0 = cyc;
        @(negedge clk);
        restart = 1'b0;
        first_cyc = -1;
        armed = 1;
        push(1, model(2, 0, 0, 0), "R8 after restart");
        wait_empty(2000, "R8 restart");
        check("R8 restart latency", first_cyc - c0, 171);

        run_case(16'h8102, 0, 3, chop_model(2, 0, 0), "R9 chop SF2 ones", 0);
        check("R9 chop toggles", int'(toggles >= 4), 1);
        run_case(16'h8102, 3, 2, chop_model(2, 0, 3), "R9 chop SF2 1110", 0);
        run_case(16'h961F, 0, 1, chop_model(31, 0, 0), "R9 chop 0x961F", 0);

        done = 1;
    end

    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule